// File: doc/BRIEF.md
# FIFO-Fed DMA Write Channel

This block is one DMA channel that takes 16-bit words from a host CPU through a small FIFO and writes them to a destination memory port. The host first loads a request length, which raises the "transfer active" flag. It then pushes words one at a time. Each time the FIFO fill level reaches a non-zero multiple of four, the block records a pending transfer request. When the channel is armed, it drains the FIFO word by word to an address that advances by two bytes per word.

The block keeps two counts. The channel transfer count and the host request length both drop by one for every word moved. When the transfer count reaches zero, the channel's transfer-end flag is set and the channel stops. When the request length reaches zero, the host "transfer active" flag clears.

The control state machine has two states. In `ST_IDLE` no word moves. The transition *start* leads from `ST_IDLE` to `ST_DRAIN` when a request is pending and the channel is armed; taking it consumes the request. In `ST_DRAIN` one word moves per clock cycle while `out_valid` and `out_ready` are both high. The transition *stop* leads back to `ST_IDLE` in the first cycle in which `out_valid` is low, which happens when the FIFO is empty, the transfer count is zero, or the channel is no longer armed.

Top module: `fifo_dma_wr`

## Requirements
- R1: Words leave in the order they were pushed, 16 bits each. The first word goes to the loaded destination address, and the address increases by 2 after every word accepted on the destination port.
- R2: `dreq` is set only by a host push after which the FIFO fill level is a non-zero multiple of four. Any other fill level leaves it unchanged. The request stays pending until the *start* transition consumes it.
- R3: The channel is armed only when `chan_ctl[1:0]` (bit 1 = transfer end, bit 0 = enable) equals 2'b01 and the global enable bit (`op_wdata`) is set. No word moves while it is not armed.
- R4: Each word moved decrements both `cnt_out` and `len_out` by one. Draining stops when the transfer count is zero or the FIFO is empty, and any words left stay in the FIFO.
- R5: `fifo_full` is 1 exactly when the FIFO holds DEPTH words (8 by default). It returns to 0 once words have been drained.
- R6: Loading a non-zero request length sets `xfer_active`. The word that brings `len_out` to zero clears it.
- R7: The word that brings the transfer count to zero sets `chan_ctl[1]`, which disarms the channel.
- R8: A control write with the enable bit set clears bits 31..24 of the transfer count.
- R9: A host push made while `xfer_active` is 0 is discarded.
- R10: A host push made while the FIFO is full is discarded.
- R11: A control write with `ctl_wdata[1]`=0 clears the transfer-end bit, and writing 1 to that bit leaves it unchanged. Once the channel is re-armed, draining starts again on the next request, or on a request that was already pending.
- R12: At most one word moves per cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Push strobe from the host into the FIFO |
| host_wdata | input | 16 | Word pushed by the host |
| len_wr | input | 1 | Load strobe for the request length |
| len_wdata | input | 16 | Request length value |
| addr_wr | input | 1 | Load strobe for the destination address |
| addr_wdata | input | 32 | Destination address value |
| cnt_wr | input | 1 | Load strobe for the transfer count |
| cnt_wdata | input | 32 | Transfer count value |
| ctl_wr | input | 1 | Channel control write strobe |
| ctl_wdata | input | 2 | Bit 0 enable, bit 1 transfer end (writing 0 clears it) |
| op_wr | input | 1 | Global operation register write strobe |
| op_wdata | input | 1 | Global DMA enable |
| out_valid | output | 1 | Destination write valid |
| out_ready | input | 1 | Destination write ready |
| out_addr | output | 32 | Destination address |
| out_data | output | 16 | Destination data |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| xfer_active | output | 1 | Host transfer active flag |
| busy | output | 1 | State machine is in ST_DRAIN |
| dreq | output | 1 | Transfer request pending |
| chan_ctl | output | 2 | Channel control register (bit 1 transfer end, bit 0 enable) |
| cnt_out | output | 32 | Channel transfer count |
| len_out | output | 16 | Host request length |

## Verification
The stall and count-step properties assume that, while a word is offered or being moved, the host does not rewrite the address, count, control or global enable registers. The bench meets this by making every register write only while the channel is idle or disarmed. The address-step property assumes the destination address is not reloaded in the same cycle that a word moves. The bench loads the address once, before the first transfer. The destination's `out_ready` is held low only for a stall window and is otherwise held high.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } chan_state_e;
endpackage

// File: rtl/dma_word_fifo.sv
module dma_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty,
    output logic                         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [LW-1:0] cnt;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= wdata;
                wp      <= nxt(wp);
            end
            if (pop) rp <= nxt(rp);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    assign rdata = mem[rp];
    assign level = cnt;
    assign empty = (cnt == '0);
    assign full  = (cnt == LW'(DEPTH));
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_pend,
    input  logic        armed,
    input  logic        can_move,
    output chan_state_e state,
    output logic        start,
    output logic        offer
);
    chan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        offer   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_pend && armed) begin
                    state_d = ST_DRAIN;
                    start   = 1'b1;
                end
            end
            ST_DRAIN: begin
                offer = can_move;
                if (!can_move) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/fifo_dma_wr.sv
module fifo_dma_wr
    import dma_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 32,
    parameter int CW    = 32,
    parameter int KEEP  = 24,
    parameter int LENW  = 16,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic [DW-1:0]   host_wdata,
    input  logic            len_wr,
    input  logic [LENW-1:0] len_wdata,
    input  logic            addr_wr,
    input  logic [AW-1:0]   addr_wdata,
    input  logic            cnt_wr,
    input  logic [CW-1:0]   cnt_wdata,
    input  logic            ctl_wr,
    input  logic [1:0]      ctl_wdata,
    input  logic            op_wr,
    input  logic            op_wdata,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [AW-1:0]   out_addr,
    output logic [DW-1:0]   out_data,
    output logic            fifo_full,
    output logic            xfer_active,
    output logic            busy,
    output logic            dreq,
    output logic [1:0]      chan_ctl,
    output logic [CW-1:0]   cnt_out,
    output logic [LENW-1:0] len_out
);
    localparam int FLW  = $clog2(DEPTH+1);
    localparam int STEP = DW / 8;
    localparam logic [CW-1:0] KEEP_MASK = CW'((64'd1 << KEEP) - 1);

    logic [AW-1:0]   addr_q;
    logic [CW-1:0]   cnt_q;
    logic [LENW-1:0] len_q;
    logic            act_q, en_q, te_q, glob_q, req_q;
    logic [FLW-1:0]  level, level_nx;
    logic            empty, full, accept, move, armed, start, offer, grp;
    chan_state_e     state;

    assign armed  = en_q && !te_q && glob_q;
    assign accept = host_wr && act_q && !full;
    assign move   = offer && out_ready;

    dma_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .wdata(host_wdata),
        .pop(move), .rdata(out_data),
        .level(level), .empty(empty), .full(full)
    );

    dma_chan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_pend(req_q), .armed(armed),
        .can_move(!empty && (cnt_q != '0) && armed),
        .state(state), .start(start), .offer(offer)
    );

    always_comb begin
        level_nx = level;
        if (accept && !move)      level_nx = level + 1'b1;
        else if (move && !accept) level_nx = level - 1'b1;
        grp = accept && (level_nx != '0) && (level_nx[1:0] == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            len_q  <= '0;
            act_q  <= 1'b0;
            en_q   <= 1'b0;
            te_q   <= 1'b0;
            glob_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            if (addr_wr)   addr_q <= addr_wdata;
            else if (move) addr_q <= addr_q + AW'(STEP);

            if (cnt_wr)                    cnt_q <= cnt_wdata;
            else if (ctl_wr && ctl_wdata[0]) cnt_q <= cnt_q & KEEP_MASK;
            else if (move)                 cnt_q <= cnt_q - 1'b1;

            if (len_wr) begin
                len_q <= len_wdata;
                act_q <= (len_wdata != '0);
            end else if (move && len_q != '0) begin
                len_q <= len_q - 1'b1;
                if (len_q == LENW'(1)) act_q <= 1'b0;
            end

            if (ctl_wr) begin
                en_q <= ctl_wdata[0];
                te_q <= te_q & ctl_wdata[1];
            end else if (move && cnt_q == CW'(1)) begin
                te_q <= 1'b1;
            end

            if (op_wr) glob_q <= op_wdata;

            if (grp)        req_q <= 1'b1;
            else if (start) req_q <= 1'b0;
        end
    end

    assign out_valid   = offer;
    assign out_addr    = addr_q;
    assign fifo_full   = full;
    assign xfer_active = act_q;
    assign busy        = (state == ST_DRAIN);
    assign dreq        = req_q;
    assign chan_ctl    = {te_q, en_q};
    assign cnt_out     = cnt_q;
    assign len_out     = len_q;
endmodule

// File: rtl/fifo_dma_wr_chk.sv
module fifo_dma_wr_chk #(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic [DW-1:0] out_data,
    input logic [CW-1:0] cnt_out,
    input logic [1:0]    chan_ctl,
    input logic          glob_en,
    input logic          fifo_full,
    input logic          addr_wr,
    input logic          cnt_wr,
    input logic          ctl_wr,
    input logic          op_wr
);
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !addr_wr |=> out_addr == $past(out_addr) + AW'(DW/8));

    a_r3_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (chan_ctl == 2'b01) && glob_en);

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !cnt_wr && !ctl_wr |=> cnt_out == $past(cnt_out) - 1'b1);

    a_r4_no_zero_move: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cnt_out != '0);

    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && !(out_valid && out_ready) |=> fifo_full);

    a_r7_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && cnt_out == CW'(1) && !ctl_wr |=> chan_ctl[1]);

    a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !ctl_wr && !op_wr && !cnt_wr && !addr_wr
        |=> out_valid && $stable(out_addr) && $stable(out_data));
endmodule

bind fifo_dma_wr fifo_dma_wr_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .cnt_out(cnt_out),
    .chan_ctl(chan_ctl), .glob_en(glob_q), .fifo_full(fifo_full),
    .addr_wr(addr_wr), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr), .op_wr(op_wr)
);

// File: tb/tb_fifo_dma_wr.sv
module tb_fifo_dma_wr;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_wr = 0;
    logic [15:0] host_wdata = 0;
    logic        len_wr = 0;
    logic [15:0] len_wdata = 0;
    logic        addr_wr = 0;
    logic [31:0] addr_wdata = 0;
    logic        cnt_wr = 0;
    logic [31:0] cnt_wdata = 0;
    logic        ctl_wr = 0;
    logic [1:0]  ctl_wdata = 0;
    logic        op_wr = 0;
    logic        op_wdata = 0;
    logic        out_valid;
    logic        out_ready = 1;
    logic [31:0] out_addr;
    logic [15:0] out_data;
    logic        fifo_full, xfer_active, busy, dreq;
    logic [1:0]  chan_ctl;
    logic [31:0] cnt_out;
    logic [15:0] len_out;

    int compared = 0;
    int mismatched = 0;
    logic [47:0] sb[$];

    always #4 clk = ~clk;

    fifo_dma_wr dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_word(logic [31:0] a, logic [15:0] d);
        sb.push_back({a, d});
    endtask

    // monitor: compare every accepted destination word with the scoreboard (R1, R12)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R1: actual unexpected word %h@%h expected none", out_data, out_addr);
            end else begin
                logic [47:0] e;
                e = sb.pop_front();
                check("R1", {out_addr[15:0], out_data}, {e[31:16], e[15:0]});
                check("R1", out_addr, e[47:16]);
            end
        end
    end

    task automatic pulse_host(logic [15:0] d);
        @(posedge clk); #1 host_wr = 1; host_wdata = d;
        @(posedge clk); #1 host_wr = 0;
    endtask
    task automatic set_len(logic [15:0] v);
        @(posedge clk); #1 len_wr = 1; len_wdata = v;
        @(posedge clk); #1 len_wr = 0;
    endtask
    task automatic set_addr(logic [31:0] v);
        @(posedge clk); #1 addr_wr = 1; addr_wdata = v;
        @(posedge clk); #1 addr_wr = 0;
    endtask
    task automatic set_cnt(logic [31:0] v);
        @(posedge clk); #1 cnt_wr = 1; cnt_wdata = v;
        @(posedge clk); #1 cnt_wr = 0;
    endtask
    task automatic set_ctl(logic [1:0] v);
        @(posedge clk); #1 ctl_wr = 1; ctl_wdata = v;
        @(posedge clk); #1 ctl_wr = 0;
    endtask
    task automatic set_op(logic v);
        @(posedge clk); #1 op_wr = 1; op_wdata = v;
        @(posedge clk); #1 op_wr = 0;
    endtask
    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        settle(1);
        // reset state
        check("R6 reset", {31'd0, xfer_active}, 0);
        check("R5 reset", {31'd0, fifo_full}, 0);
        check("R2 reset", {29'd0, dreq, busy, out_valid}, 0);
        check("R7 reset", {30'd0, chan_ctl}, 0);

        // R9: pushes with transfer inactive are dropped
        for (int i = 0; i < 4; i++) pulse_host(16'hDEA0 + 16'(i));
        settle(2);
        check("R9", {31'd0, dreq}, 0);

        // set up channel; R8 masks upper byte on start
        set_len(6);
        set_addr(32'h1000);
        set_cnt(32'hAB000006);
        set_op(1);
        set_ctl(2'b01);
        settle(1);
        check("R8", cnt_out, 32'd6);
        check("R6", {31'd0, xfer_active}, 1);

        // R2: three words raise no request
        for (int i = 0; i < 3; i++) pulse_host(16'hA000 + 16'(i));
        settle(3);
        check("R2", {30'd0, dreq, busy}, 0);
        for (int i = 0; i < 4; i++) expect_word(32'h1000 + 32'(2*i), 16'hA000 + 16'(i));
        pulse_host(16'hA003);
        settle(10);
        check("R4 count", cnt_out, 32'd2);
        check("R4 len", {16'd0, len_out}, 32'd2);
        check("R1 drained", sb.size(), 0);

        // R4/R7/R6: count reaches zero with words left
        expect_word(32'h1008, 16'hA004);
        expect_word(32'h100A, 16'hA005);
        for (int i = 4; i < 8; i++) pulse_host(16'hA000 + 16'(i));
        settle(10);
        check("R7", {30'd0, chan_ctl}, 32'd3);
        check("R4 stop", cnt_out, 0);
        check("R6 cleared", {31'd0, xfer_active}, 0);
        check("R4 idle", {30'd0, busy, out_valid}, 0);

        // R11: clear end flag, no drain until next request
        set_len(8);
        set_cnt(4);
        set_ctl(2'b01);
        settle(4);
        check("R11 cleared", {30'd0, chan_ctl}, 32'd1);
        check("R11 wait", {30'd0, busy, out_valid}, 0);
        for (int i = 6; i < 10; i++) expect_word(32'h1000 + 32'(2*i), 16'hA000 + 16'(i));
        pulse_host(16'hA008);
        pulse_host(16'hA009);
        settle(10);
        check("R11 resume", sb.size(), 0);
        check("R7 again", {30'd0, chan_ctl}, 32'd3);
        check("R4 len", {16'd0, len_out}, 32'd4);

        // R3: global enable off holds request
        set_op(0);
        set_cnt(8);
        set_ctl(2'b01);
        for (int i = 10; i < 14; i++) pulse_host(16'hA000 + 16'(i));
        settle(4);
        check("R3 pending", {31'd0, dreq}, 1);
        check("R3 no move", {31'd0, out_valid}, 0);
        for (int i = 10; i < 14; i++) expect_word(32'h1000 + 32'(2*i), 16'hA000 + 16'(i));
        set_op(1);
        settle(10);
        check("R3 drained", sb.size(), 0);
        check("R6 len zero", {15'd0, xfer_active, len_out}, 0);
        check("R4 count", cnt_out, 32'd4);

        // R5/R10/R12: fill, overflow, stall
        set_len(20);
        set_ctl(2'b00);
        for (int i = 14; i < 23; i++) pulse_host(16'hA000 + 16'(i));
        settle(1);
        check("R5 full", {31'd0, fifo_full}, 1);
        @(posedge clk); #1 out_ready = 0;
        set_cnt(16);
        set_ctl(2'b01);
        settle(3);
        check("R12 valid", {31'd0, out_valid}, 1);
        check("R12 hold", {out_addr[15:0], out_data}, {16'h101C, 16'hA00E});
        settle(1);
        check("R12 hold2", {out_addr[15:0], out_data}, {16'h101C, 16'hA00E});
        for (int i = 14; i < 22; i++) expect_word(32'h1000 + 32'(2*i), 16'hA000 + 16'(i));
        @(posedge clk); #1 out_ready = 1;
        settle(15);
        check("R10 dropped", sb.size(), 0);
        check("R10 count", cnt_out, 32'd8);
        check("R10 empty", {30'd0, busy, out_valid}, 0);
        check("R5 cleared", {31'd0, fifo_full}, 0);
        check("R4 len", {16'd0, len_out}, 32'd12);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule